// File: doc/BRIEF.md
# Pipelined 1.33 Fixed-Point Multiplier

This block multiplies two signed fixed-point words held in a 35-bit 1.33 format (a sign bit, one integer bit, thirty-three fraction bits) and returns their product in the same format. The result is rounded to the nearest code and clamped to the representable span. An overflow flag marks any result that had to be clamped. It is meant for datapaths whose values stay between -2 and 2 and where every multiply must map onto narrow signed multiplier primitives.

The wide product is never written as one large multiply. Each operand is split into an upper signed 18-bit slice and a lower 17-bit slice, and the lower slice is treated as unsigned. Four 18×18 signed products are formed and then shifted and summed into the exact 70-bit product. That product is rounded and rescaled back to 1.33.

The pipeline has three register stages and takes a new pair on every clock. A valid strobe travels alongside the data.

Top module: `fxp_mul_q133`

## Requirements
- R1: A word's value is -2·bit34 + bit33 + bits[32:0]·2^-33. For any pair whose rounded product lies in range, `result` holds that rounded product and `ovf` is 0. This includes operands whose bit 16 is set.
- R2: A pair sampled at rising edge n with `inValid` high gives `outValid` high and its `result` between edge n+2 and edge n+3. `outValid` equals `inValid` as sampled three edges earlier.
- R3: A new pair is accepted on every edge. Results leave in arrival order, and cycles with `inValid` low reappear as cycles with `outValid` low in the same positions.
- R4: Rounding is to nearest, and an exact half LSB rounds toward plus infinity. So 0.5 × 2^-33 gives code 0x000000001, -0.5 × 2^-33 gives 0, and 1.5 × 2^-33 gives code 0x000000002.
- R5: A rounded product above 2-2^-33 yields code 0x3FFFFFFFF with `ovf` 1. Examples are (-2)×(-2), 1.5×1.5 and max×max.
- R6: A rounded product below -2 yields code 0x400000000 with `ovf` 1. Examples are (-2)×max and 1.5×(-1.5).
- R7: (-2)×1 gives exactly 0x400000000 with `ovf` 0, and 1.0 (code 0x200000000) times x gives x.
- R8: `ovf` is 0 in every cycle where `outValid` is 0.
- R9: A synchronous active-high `rst` clears every valid stage and `ovf`. Pairs in flight when `rst` is sampled never appear at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operand pair on `opA`/`opB` is valid this cycle |
| opA | input | 35 | First operand, 1.33 two's complement |
| opB | input | 35 | Second operand, 1.33 two's complement |
| outValid | output | 1 | `result` carries a product this cycle |
| result | output | 35 | Rounded, saturated product, 1.33 two's complement |
| ovf | output | 1 | The product was clamped to an end code |

## Verification
The assertions rely on a few conditions about the inputs. `rst` must be sampled high at the first clock edge. `inValid` must always be a known 0 or 1. The delay check only applies once three edges have passed since reset released, so it never compares against reset-time strobes. The stimulus holds reset for several cycles and drives every input at the falling edge, leaving values settled well before the sampling edge. It also keeps `inValid` strictly binary, including across the mid-stream reset used to show that in-flight pairs are dropped.

// File: rtl/fxm_pkg.sv
package fxm_pkg;

  // Per-stage load strobes handed from the control to the datapath
  typedef struct packed {
    logic ldProd;   // capture the four partial products
    logic ldSum;    // capture the recombined wide product
    logic ldOut;    // capture the rounded and clamped result
  } fxmStrobe_t;

endpackage

// File: rtl/fxm_ctrl.sv
module fxm_ctrl
  import fxm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  output fxmStrobe_t stb,
  output logic       outValid
);

  localparam int STAGES = 3;

  logic [STAGES-1:0] vPipe;

  always_ff @(posedge clk) begin
    if (rst) vPipe <= '0;
    else     vPipe <= {vPipe[STAGES-2:0], inValid};
  end

  assign stb.ldProd = inValid;
  assign stb.ldSum  = vPipe[0];
  assign stb.ldOut  = vPipe[1];
  assign outValid   = vPipe[STAGES-1];

  // Edges seen since reset release, saturating, for the delay check
  logic [1:0] warmCnt;
  always_ff @(posedge clk) begin
    if (rst)                 warmCnt <= '0;
    else if (warmCnt != 2'd3) warmCnt <= warmCnt + 2'd1;
  end

  // R2: output strobe is the input strobe three edges late
  a_r2_valid_delay: assert property (@(posedge clk) disable iff (rst || warmCnt != 2'd3)
    outValid == $past(inValid, 3));

  // R9: a sampled reset empties the pipeline
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> !outValid);

endmodule

// File: rtl/fxm_datapath.sv
module fxm_datapath
  import fxm_pkg::*;
#(
  parameter int DATA_W = 35,
  parameter int FRAC_W = 33,
  parameter int PRIM_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  fxmStrobe_t        stb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              ovf
);

  localparam int LO_W   = DATA_W - PRIM_W;      // unsigned low slice width
  localparam int PP_W   = 2 * PRIM_W;           // one primitive product
  localparam int NPP    = 4;
  localparam int PROD_W = 2 * DATA_W;           // exact product width
  localparam int RES_W  = PROD_W - FRAC_W;      // width after rescale
  localparam int GUARD  = RES_W - DATA_W + 1;   // bits that must agree
  localparam logic [PROD_W-1:0] ROUND_K = {{(PROD_W-1){1'b0}}, 1'b1} << (FRAC_W - 1);
  localparam logic [DATA_W-1:0] MAX_CODE = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_CODE = {1'b1, {(DATA_W-1){1'b0}}};

  // Operand slices: index 0 = low (zero-extended), index 1 = high (signed)
  logic [1:0][PRIM_W-1:0] aPart, bPart;
  assign aPart[0] = {{(PRIM_W-LO_W){1'b0}}, opA[LO_W-1:0]};
  assign aPart[1] = opA[DATA_W-1:LO_W];
  assign bPart[0] = {{(PRIM_W-LO_W){1'b0}}, opB[LO_W-1:0]};
  assign bPart[1] = opB[DATA_W-1:LO_W];

  // Four signed 18x18 primitive multiplies; entry = 2*aIndex + bIndex
  logic [NPP-1:0][PP_W-1:0] ppNext, ppQ;
  generate
    for (genvar gi = 0; gi < 2; gi++) begin : g_aSlice
      for (genvar gj = 0; gj < 2; gj++) begin : g_bSlice
        assign ppNext[2*gi+gj] = PP_W'(
          $signed({{PRIM_W{aPart[gi][PRIM_W-1]}}, aPart[gi]}) *
          $signed({{PRIM_W{bPart[gj][PRIM_W-1]}}, bPart[gj]}));
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (stb.ldProd) ppQ <= ppNext;
  end

  function automatic logic [PROD_W-1:0] widen(input logic [PP_W-1:0] v);
    return {{(PROD_W-PP_W){v[PP_W-1]}}, v};
  endfunction

  // Recombine: HH<<2L + (HL+LH)<<L + LL
  logic [PROD_W-1:0] crossSum, prodFull, sumQ;
  assign crossSum = widen(ppQ[1]) + widen(ppQ[2]);
  assign prodFull = (widen(ppQ[3]) << (2 * LO_W)) + (crossSum << LO_W) + widen(ppQ[0]);

  always_ff @(posedge clk) begin
    if (stb.ldSum) sumQ <= prodFull;
  end

  // Round half up, drop the extra fraction bits, clamp
  logic [PROD_W-1:0] rounded;
  logic [RES_W-1:0]  scaled;
  logic [GUARD-1:0]  guardBits;
  logic              inRange;
  logic [DATA_W-1:0] satCode;

  assign rounded   = sumQ + ROUND_K;
  assign scaled    = RES_W'(rounded >> FRAC_W);
  assign guardBits = scaled[RES_W-1:DATA_W-1];
  assign inRange   = (&guardBits) | ~(|guardBits);
  assign satCode   = scaled[RES_W-1] ? MIN_CODE : MAX_CODE;

  logic [DATA_W-1:0] resQ;
  logic              ovfQ;

  always_ff @(posedge clk) begin
    if (stb.ldOut) resQ <= inRange ? scaled[DATA_W-1:0] : satCode;
  end

  always_ff @(posedge clk) begin
    if (rst) ovfQ <= 1'b0;
    else     ovfQ <= stb.ldOut & ~inRange;
  end

  assign result = resQ;
  assign ovf    = ovfQ;

  // R5 / R6: a flagged result sits on one of the two end codes
  a_r5_sat_code: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (result == MAX_CODE || result == MIN_CODE));

endmodule

// File: rtl/fxp_mul_q133.sv
module fxp_mul_q133
  import fxm_pkg::*;
#(
  parameter int DATA_W = 35,
  parameter int FRAC_W = 33,
  parameter int PRIM_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              ovf
);

  fxmStrobe_t stb;

  fxm_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .stb      (stb),
    .outValid (outValid)
  );

  fxm_datapath #(
    .DATA_W (DATA_W),
    .FRAC_W (FRAC_W),
    .PRIM_W (PRIM_W)
  ) dp_i (
    .clk    (clk),
    .rst    (rst),
    .stb    (stb),
    .opA    (opA),
    .opB    (opB),
    .result (result),
    .ovf    (ovf)
  );

  // R8: the flag never stands on a cycle without a result
  a_r8_ovf_needs_valid: assert property (@(posedge clk) disable iff (rst)
    ovf |-> outValid);

endmodule

// File: tb/fxp_mul_q133_tb_top.sv
module fxp_mul_q133_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [34:0] opA, opB;
  logic        outValid;
  logic [34:0] result;
  logic        ovf;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit monOn = 0;
  bit done = 0;

  localparam logic [34:0] ONE   = 35'h200000000;
  localparam logic [34:0] NEG1  = 35'h600000000;
  localparam logic [34:0] NEG2  = 35'h400000000;
  localparam logic [34:0] HALF  = 35'h100000000;
  localparam logic [34:0] NHALF = 35'h700000000;
  localparam logic [34:0] P15   = 35'h300000000;
  localparam logic [34:0] N15   = 35'h500000000;
  localparam logic [34:0] MAXC  = 35'h3FFFFFFFF;

  fxp_mul_q133 dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
    .outValid(outValid), .result(result), .ovf(ovf)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [34:0] res;
    logic        ovf;
    int          due;
    string       tag;
  } exp_t;

  exp_t sbq[$];
  exp_t mE;

  task automatic chk(input bit ok, input string tag, input logic [34:0] act, input logic [34:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Reference: one wide multiply, round half up, clamp
  task automatic model(input logic [34:0] a, input logic [34:0] b,
                       output logic [34:0] r, output logic o);
    logic signed [71:0] p, q;
    p = $signed({{37{a[34]}}, a}) * $signed({{37{b[34]}}, b});
    q = (p + 72'sd4294967296) >>> 33;
    if (q > 72'sd17179869183) begin r = MAXC; o = 1'b1; end
    else if (q < -72'sd17179869184) begin r = NEG2; o = 1'b1; end
    else begin r = q[34:0]; o = 1'b0; end
  endtask

  task automatic drive(input logic [34:0] a, input logic [34:0] b, input string tag);
    exp_t e;
    @(negedge clk);
    opA = a; opB = b; inValid = 1'b1;
    model(a, b, e.res, e.ovf);
    e.due = cyc + 3;
    e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  function automatic logic [34:0] rnd35();
    return 35'({$urandom(), $urandom()});
  endfunction

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (monOn && !done) begin
      if (outValid) begin
        if (sbq.size() == 0) chk(1'b0, "R3 unexpected output", result, 35'h0);
        else begin
          mE = sbq.pop_front();
          chk(cyc == mE.due, "R2 latency", 35'(cyc), 35'(mE.due));
          chk(result == mE.res, mE.tag, result, mE.res);
          chk(ovf == mE.ovf, {mE.tag, " ovf"}, 35'(ovf), 35'(mE.ovf));
        end
      end else begin
        chk(ovf == 1'b0, "R8 ovf without valid", 35'(ovf), 35'h0);
        if (sbq.size() > 0 && sbq[0].due <= cyc) begin
          chk(1'b0, "R2 missing output", 35'(cyc), 35'(sbq[0].due));
          void'(sbq.pop_front());
        end
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc == 100000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; inValid = 1'b0; opA = '0; opB = '0;
    repeat (2) @(negedge clk);
    inValid = 1'b1; opA = NEG2; opB = NEG2;
    repeat (3) @(negedge clk);
    rst = 1'b0; inValid = 1'b0;
    // R9: reset state
    repeat (3) begin
      chk(outValid == 1'b0 && ovf == 1'b0, "R9 reset state", {33'h0, outValid, ovf}, 35'h0);
      @(negedge clk);
    end

    // R9: pairs in flight are dropped by a mid-stream reset
    inValid = 1'b1; opA = NEG2; opB = NEG2;
    @(negedge clk);
    @(negedge clk);
    inValid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (4) begin
      chk(outValid == 1'b0 && ovf == 1'b0, "R9 flush", {33'h0, outValid, ovf}, 35'h0);
      @(negedge clk);
    end

    monOn = 1;
    // R1 basic products
    drive(ONE, 35'h180000000, "R1 1x0.75");
    drive(NEG1, HALF, "R1 -1x0.5");
    drive(35'h00001FFFF, 35'h1FFFF0000, "R1 bit16 set");
    drive(35'h7FFFE8001, 35'h00001C000, "R1 neg low slice");
    // R7
    drive(ONE, 35'h123456789, "R7 identity");
    drive(NEG2, ONE, "R7 -2x1");
    // R4 rounding
    drive(HALF, 35'h000000001, "R4 half up");
    drive(NHALF, 35'h000000001, "R4 neg half");
    drive(P15, 35'h000000001, "R4 1.5 lsb");
    idle(1);
    // R5 / R6 saturation
    drive(NEG2, NEG2, "R5 -2x-2");
    drive(P15, P15, "R5 1.5x1.5");
    drive(MAXC, MAXC, "R5 max x max");
    drive(NEG2, MAXC, "R6 -2 x max");
    drive(P15, N15, "R6 1.5x-1.5");
    idle(2);
    // R3 back-to-back with bubbles, mixed ranges
    for (int i = 0; i < 400; i++) begin
      logic [34:0] a, b;
      a = rnd35();
      b = rnd35();
      if (i % 2 == 0) begin
        a = {a[34], a[34:1]};
        b = {b[34], b[34:1]};
        drive(a, b, "R1 random in-range");
      end else begin
        drive(a, b, "R3 random stream");
      end
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 2));
    end
    idle(6);
    chk(sbq.size() == 0, "R3 queue drained", 35'(sbq.size()), 35'h0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule